// File: doc/BRIEF.md
# Four-Bit Register-File Datapath

This block is the execute and write-back slice of a very small 4-bit processor. It takes one 9-bit instruction word per clock cycle and uses its fields to address a bank of four 4-bit registers. Two registers are read with no clock delay and fed to a small arithmetic/logic unit. On the next rising edge, one value is written back into a destination register. Fetch, sequencing and memory access belong to the surrounding logic, which presents an instruction and a write enable each cycle.

The value written back is chosen by a 4-bit two-way multiplexer. A decoder drives its select line from the 3-bit opcode. The opcode 3'b100 is a load-immediate: for it, the decoder steers a 4-bit constant from the instruction word to the register bank. The constant sits in the bits otherwise used for the two source addresses. For every other opcode, the ALU result is written. The ALU result and the contents of every register are visible on output ports for observation.

Top module: `cpu4_datapath`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four registers are cleared, so `reg_view` reads 0 after that edge.
- R2: When `instr[8:6]` is 3'b100 (load-immediate) and `wr_en` is high, the register addressed by `instr[1:0]` receives `instr[5:2]` at the next rising edge.
- R3: Opcode 3'b000 adds: `alu_result` is (first source + second source) modulo 16, and any carry out is dropped.
- R4: Opcode 3'b001 subtracts: `alu_result` is (first source − second source) modulo 16.
- R5: Opcode 3'b010 gives the bitwise AND of the two sources, and opcode 3'b011 gives their bitwise OR.
- R6: Opcodes 3'b100 through 3'b111 give an `alu_result` of 0. An opcode from 3'b101 to 3'b111 with `wr_en` high writes 0 into the destination register.
- R7: With `wr_en` low, no register changes at the clock edge, whatever the instruction.
- R8: Field positions: the first source address is `instr[5:4]`, the second is `instr[3:2]` and the destination is `instr[1:0]`. For opcodes other than 3'b100, the ALU result is written to the destination, and no other register changes.
- R9: Both reads are combinational. When the register being written is also read in the same cycle, `alu_result` reflects the value held before the edge.
- R10: `wb_take_alu` is 0 only when the opcode is 3'b100, and 1 for the other seven opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the register bank |
| wr_en | input | 1 | Allows the write-back at the next edge |
| instr | input | 9 | Instruction word: opcode, source/immediate fields, destination |
| wb_take_alu | output | 1 | Write-back select: 0 picks the immediate, 1 picks the ALU result |
| alu_result | output | 4 | Combinational ALU output for the current instruction |
| reg_view | output | 16 | Register contents, register k in bits [4k+3:4k] |

## Verification
The cycle that matters most is one where a register is read and written at once. The bench issues a add or subtract instruction whose destination is also one of its sources, for example doubling r1 into r1 on two cycles in a row. During the write cycle, it checks that the ALU output is still built from the value held before the edge. After the edge, it checks that the register holds that result and that the following instruction reads the new value. Load-immediate writes into a register that was just read are handled the same way, with a reference model of the bank in the bench.

// File: rtl/cpu4_pkg.sv
package cpu4_pkg;
  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD = 3'b000,
    OPC_SUB = 3'b001,
    OPC_AND = 3'b010,
    OPC_OR  = 3'b011,
    OPC_LDI = 3'b100
  } opc_e;
endpackage

// File: rtl/cpu4_ldi_decode.sv
module cpu4_ldi_decode
  import cpu4_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output logic             take_alu
);
  assign take_alu = (opcode == OPC_LDI) ? 1'b0 : 1'b1;
endmodule

// File: rtl/cpu4_wb_mux.sv
module cpu4_wb_mux #(
  parameter int WIDTH = 4
) (
  input  logic             sel,
  input  logic [WIDTH-1:0] in0,
  input  logic [WIDTH-1:0] in1,
  output logic [WIDTH-1:0] out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign out[b] = sel ? in1[b] : in0[b];
  end
endmodule

// File: rtl/cpu4_alu.sv
module cpu4_alu
  import cpu4_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    case (opcode)
      OPC_ADD: result = op_a + op_b;
      OPC_SUB: result = op_a - op_b;
      OPC_AND: result = op_a & op_b;
      OPC_OR:  result = op_a | op_b;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/cpu4_regbank.sv
module cpu4_regbank #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 2,
  localparam int NREG  = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      waddr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [ADDR_W-1:0]      raddr_a,
  input  logic [ADDR_W-1:0]      raddr_b,
  output logic [DATA_W-1:0]      rdata_a,
  output logic [DATA_W-1:0]      rdata_b,
  output logic [NREG*DATA_W-1:0] view
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (we && waddr == ADDR_W'(i))
        regs[i] <= wdata;
    end
    assign view[i*DATA_W +: DATA_W] = regs[i];
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/cpu4_datapath.sv
module cpu4_datapath
  import cpu4_pkg::*;
#(
  parameter int DATA_W   = 4,
  parameter int ADDR_W   = 2,
  localparam int NREG    = 1 << ADDR_W,
  localparam int INSTR_W = OPC_W + 3*ADDR_W,
  localparam int IMM_W   = 2*ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [INSTR_W-1:0]     instr,
  output logic                   wb_take_alu,
  output logic [DATA_W-1:0]      alu_result,
  output logic [NREG*DATA_W-1:0] reg_view
);
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] src_a, src_b, dst;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] imm_ext, rd_a, rd_b, wb_data;

  assign opcode  = instr[INSTR_W-1 -: OPC_W];
  assign src_a   = instr[3*ADDR_W-1 -: ADDR_W];
  assign src_b   = instr[2*ADDR_W-1 -: ADDR_W];
  assign dst     = instr[ADDR_W-1:0];
  assign imm     = instr[3*ADDR_W-1 -: IMM_W];
  assign imm_ext = DATA_W'(imm);

  cpu4_ldi_decode u_dec (
    .opcode   (opcode),
    .take_alu (wb_take_alu)
  );

  cpu4_alu #(.DATA_W(DATA_W)) u_alu (
    .opcode (opcode),
    .op_a   (rd_a),
    .op_b   (rd_b),
    .result (alu_result)
  );

  cpu4_wb_mux #(.WIDTH(DATA_W)) u_mux (
    .sel (wb_take_alu),
    .in0 (imm_ext),
    .in1 (alu_result),
    .out (wb_data)
  );

  cpu4_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .waddr   (dst),
    .wdata   (wb_data),
    .raddr_a (src_a),
    .raddr_b (src_b),
    .rdata_a (rd_a),
    .rdata_b (rd_b),
    .view    (reg_view)
  );
endmodule

// File: rtl/cpu4_datapath_chk.sv
module cpu4_datapath_chk #(
  parameter int DATA_W   = 4,
  parameter int ADDR_W   = 2,
  localparam int NREG    = 1 << ADDR_W,
  localparam int INSTR_W = 3 + 3*ADDR_W
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [INSTR_W-1:0]     instr,
  input logic                   wb_take_alu,
  input logic [DATA_W-1:0]      alu_result,
  input logic [NREG*DATA_W-1:0] reg_view
);
  function automatic logic [DATA_W-1:0] slot(input logic [NREG*DATA_W-1:0] v,
                                              input logic [ADDR_W-1:0] idx);
    return v[idx*DATA_W +: DATA_W];
  endfunction

  logic [2:0] opc;
  assign opc = instr[INSTR_W-1 -: 3];

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> reg_view == '0);

  a_r2_ldi_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && opc == 3'b100) |=>
      slot(reg_view, $past(instr[ADDR_W-1:0])) == DATA_W'($past(instr[3*ADDR_W-1 -: 2*ADDR_W])));

  a_r6_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (opc[2] == 1'b1) |-> alu_result == '0);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(reg_view));

  a_r8_alu_writeback: assert property (@(posedge clk) disable iff (rst)
    (wr_en && opc != 3'b100) |=>
      slot(reg_view, $past(instr[ADDR_W-1:0])) == $past(alu_result));

  a_r10_sel_low_ldi: assert property (@(posedge clk) disable iff (rst)
    !wb_take_alu |-> opc == 3'b100);
endmodule

bind cpu4_datapath cpu4_datapath_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .instr       (instr),
  .wb_take_alu (wb_take_alu),
  .alu_result  (alu_result),
  .reg_view    (reg_view)
);

// File: tb/cpu4_datapath_tb.sv
module cpu4_datapath_tb;
  localparam int PERIOD = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [8:0]  instr = '0;
  logic        wb_take_alu;
  logic [3:0]  alu_result;
  logic [15:0] reg_view;

  int tests = 0;
  int fails = 0;
  logic [3:0] m [4];

  always #(PERIOD/2) clk = ~clk;

  cpu4_datapath u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .instr(instr),
    .wb_take_alu(wb_take_alu), .alu_result(alu_result), .reg_view(reg_view)
  );

  function automatic logic [15:0] model_view();
    return {m[3], m[2], m[1], m[0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one instruction, check the combinational outputs during the cycle
  // and the register bank after the edge against the bench model.
  task automatic run_op(input logic [2:0] op, input logic [1:0] a, input logic [1:0] b,
                        input logic [1:0] d, input logic [3:0] imm, input bit we,
                        input string req);
    logic [3:0] exp_alu;
    @(negedge clk);
    instr = (op == 3'b100) ? {op, imm, d} : {op, a, b, d};
    wr_en = we;
    case (op)
      3'b000:  exp_alu = m[a] + m[b];
      3'b001:  exp_alu = m[a] - m[b];
      3'b010:  exp_alu = m[a] & m[b];
      3'b011:  exp_alu = m[a] | m[b];
      default: exp_alu = 4'h0;
    endcase
    #1;
    check(alu_result == exp_alu, {req, " alu"}, 16'(alu_result), 16'(exp_alu));
    check(wb_take_alu == (op != 3'b100), "R10 select", 16'(wb_take_alu),
          16'(op != 3'b100));
    @(posedge clk);
    if (we) m[d] = (op == 3'b100) ? imm : exp_alu;
    #1;
    check(reg_view == model_view(), {req, " regs"}, reg_view, model_view());
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    for (int i = 0; i < 4; i++) m[i] = 4'h0;
    check(reg_view == 16'h0, "R1 reset clear", reg_view, 16'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_load();
    run_op(3'b100, 0, 0, 2'd0, 4'h5, 1'b1, "R2 ldi r0");
    run_op(3'b100, 0, 0, 2'd1, 4'hA, 1'b1, "R2 ldi r1");
    run_op(3'b100, 0, 0, 2'd2, 4'hF, 1'b1, "R2 ldi r2");
    run_op(3'b100, 0, 0, 2'd3, 4'h3, 1'b1, "R2 R8 ldi r3");
  endtask

  task automatic t_arith();
    run_op(3'b000, 2'd0, 2'd1, 2'd2, 0, 1'b1, "R3 add 5+A");
    run_op(3'b000, 2'd2, 2'd2, 2'd2, 0, 1'b1, "R3 add wrap F+F");
    run_op(3'b001, 2'd3, 2'd0, 2'd1, 0, 1'b1, "R4 sub 3-5");
    run_op(3'b001, 2'd0, 2'd3, 2'd3, 0, 1'b1, "R4 R8 sub 5-3");
  endtask

  task automatic t_logic();
    run_op(3'b100, 0, 0, 2'd2, 4'hC, 1'b1, "R2 ldi C");
    run_op(3'b010, 2'd2, 2'd1, 2'd0, 0, 1'b1, "R5 and");
    run_op(3'b011, 2'd2, 2'd3, 2'd3, 0, 1'b1, "R5 or");
  endtask

  task automatic t_unused();
    run_op(3'b101, 2'd1, 2'd2, 2'd1, 0, 1'b1, "R6 op101");
    run_op(3'b110, 2'd2, 2'd3, 2'd2, 0, 1'b1, "R6 op110");
    run_op(3'b111, 2'd3, 2'd3, 2'd0, 0, 1'b1, "R6 op111");
  endtask

  task automatic t_hold();
    run_op(3'b100, 0, 0, 2'd3, 4'h9, 1'b0, "R7 ldi no wr");
    run_op(3'b000, 2'd3, 2'd3, 2'd3, 0, 1'b0, "R7 add no wr");
    run_op(3'b101, 2'd3, 2'd3, 2'd1, 0, 1'b0, "R7 op101 no wr");
  endtask

  task automatic t_raw();
    run_op(3'b100, 0, 0, 2'd1, 4'h3, 1'b1, "R2 ldi 3");
    run_op(3'b000, 2'd1, 2'd1, 2'd1, 0, 1'b1, "R9 double r1");
    run_op(3'b000, 2'd1, 2'd1, 2'd1, 0, 1'b1, "R9 double again");
    run_op(3'b001, 2'd1, 2'd0, 2'd1, 0, 1'b1, "R9 sub into src");
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst = 1'b1; wr_en = 1'b1; instr = {3'b100, 4'hE, 2'd0};
    @(posedge clk); #1;
    for (int i = 0; i < 4; i++) m[i] = 4'h0;
    check(reg_view == 16'h0, "R1 reset over write", reg_view, 16'h0);
    @(negedge clk); rst = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_arith();
    t_logic();
    t_unused();
    t_hold();
    t_raw();
    t_reset_again();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule